// File: doc/BRIEF.md
# Flash Page Buffer Write Combiner

This block stages one flash page before it is programmed. A 32-bit memory-mapped write port feeds a buffer of 32 doubleword slots, each 64 bits wide. Bus writes never reach the flash array. Every aligned word write is decoded into a doubleword address. The low five bits of that address select a buffer slot, and the remaining upper bits become the page number that the next programming operation targets.

The bus is half as wide as a slot, so each slot needs two word writes. The word at byte offset 0 is held in a staging register. The slot is updated only when the word at byte offset 4 of the same doubleword follows it. Writes of the wrong size, misaligned addresses, reads, and upper words that have no matching lower word are rejected and set a sticky error flag. The buffer cannot be read back over the bus.

A page-write command streams all 32 slots, in slot order, to the flash programming side over a valid/ready handshake. The bus is stalled for the whole sequence. When the last doubleword is taken, the buffer returns to the erased pattern of all ones.

Top module: `pgbuf_combiner`

## Requirements
- R1: An aligned word write at byte offset 0 (address bit 2 clear), followed by one at byte offset 4 (address bit 2 set) with the same doubleword address (byte address bits 17:3), stores {second word, first word} into slot (doubleword address mod 32). The upper 32 bits come from the second write.
- R2: Every aligned word write sets the page output to the doubleword address divided by 32, which is byte address bits 17:8.
- R3: An upper-word write with no pending lower word, or with a pending lower word for a different doubleword address, leaves the buffer unchanged and sets the error flag. A pending lower word stays pending.
- R4: A new lower-word write replaces any pending lower word and its doubleword address.
- R5: Writes whose size code is not word (size codes: 0 byte, 1 halfword, 2 word, 3 reserved) and word writes with nonzero address bits 1:0 set the error flag. They leave the buffer, the pending lower word and the page output unchanged.
- R6: A bus read returns zero, sets the error flag, and changes no buffer or page state.
- R7: The error flag stays set until the clear input is pulsed. If a new error arrives in the same cycle as the clear, the new error wins.
- R8: A page-write command makes the flash port present slots 0 through 31 in order, together with the page output. Each beat is held until ready is high.
- R9: Busy rises in the cycle after the command and falls after the last beat is accepted. Bus ready is low while busy, and a page-write command given while busy has no effect.
- R10: After reset, and after a page write completes, every slot reads as all ones and no lower word is pending.
- R11: Slots not written since the last erase are sent as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Bus transfer request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 18 | Byte address |
| busSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| busWData | input | 32 | Write data |
| busReady | output | 1 | Transfer accepted this cycle |
| busRData | output | 32 | Read data, always zero |
| cmdWritePage | input | 1 | Start a page copy-out |
| errClear | input | 1 | Clears the sticky error flag |
| errFlag | output | 1 | Sticky error flag |
| pageNum | output | 10 | Page number field |
| busy | output | 1 | Copy-out in progress |
| flValid | output | 1 | Flash beat valid |
| flReady | input | 1 | Flash side accepts beat |
| flSlot | output | 5 | Slot index of current beat |
| flPage | output | 10 | Target page of current beat |
| flData | output | 64 | Doubleword of current beat |

## Verification
The hardest condition to reach is a lower word left pending across a page write, followed by its upper half after the erase. This exposes whether completing the copy-out drops the staged word. The stimulus writes a lone lower word, runs a full copy-out with periodic back-pressure, and then sends the matching upper word. It expects an error and an all-ones buffer on the next copy-out. A page-write command is also injected in the middle of a copy-out, and the bench confirms that busy does not rise again afterwards.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  // Size codes on the bus
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } busSize_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic stageLow;
    logic commit;
    logic loadPage;
    logic setErr;
    logic fillErased;
  } pgbufStrobes_t;
endpackage

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
  import pgbuf_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 18
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busValid,
  input  logic                  busWrite,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [1:0]            busSize,
  input  logic                  cmdWritePage,
  input  logic                  flReady,
  output logic                  busReady,
  output logic                  busy,
  output logic                  flValid,
  output logic [$clog2(SLOTS)-1:0] slotIdx,
  output pgbufStrobes_t         strb
);
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int LOW_BITS = $clog2(BUS_W / 8);
  localparam int DW_LSB   = LOW_BITS + 1;
  localparam int DWA_W    = ADDR_W - DW_LSB;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic              pendValid;
  logic [DWA_W-1:0]  pendAddr;
  logic [DWA_W-1:0]  dwAddr;
  logic              hiHalf, aligned, isWord, accept, goodWrite, pairOk, lastBeat;

  always_comb begin
    dwAddr    = busAddr[ADDR_W-1:DW_LSB];
    hiHalf    = busAddr[LOW_BITS];
    aligned   = (busAddr[LOW_BITS-1:0] == '0);
    isWord    = (busSize == SZ_WORD);
    accept    = busValid && !busy;
    goodWrite = accept && busWrite && isWord && aligned;
    pairOk    = pendValid && (pendAddr == dwAddr);
    lastBeat  = busy && flReady && (slotIdx == LAST_SLOT);

    strb.stageLow   = goodWrite && !hiHalf;
    strb.commit     = goodWrite && hiHalf && pairOk;
    strb.loadPage   = goodWrite;
    strb.setErr     = accept && (!(busWrite && isWord && aligned) || (hiHalf && !pairOk));
    strb.fillErased = lastBeat;
  end

  assign busReady = !busy;
  assign flValid  = busy;

  // Copy-out sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      slotIdx <= '0;
    end else if (!busy) begin
      if (cmdWritePage) begin
        busy    <= 1'b1;
        slotIdx <= '0;
      end
    end else if (flReady) begin
      if (slotIdx == LAST_SLOT) begin
        busy    <= 1'b0;
        slotIdx <= '0;
      end else begin
        slotIdx <= slotIdx + SLOT_W'(1);
      end
    end
  end

  // Pending lower-word tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
    end else if (lastBeat) begin
      pendValid <= 1'b0;
    end else if (strb.stageLow) begin
      pendValid <= 1'b1;
      pendAddr  <= dwAddr;
    end else if (strb.commit) begin
      pendValid <= 1'b0;
    end
  end

  p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.loadPage && !strb.setErr && !strb.stageLow);
  p_hold_beat_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy && !flReady |=> busy && $stable(slotIdx));
  p_advance_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy && flReady && (slotIdx != LAST_SLOT) |=> busy && (slotIdx == $past(slotIdx) + SLOT_W'(1)));
  p_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy && flReady && (slotIdx == LAST_SLOT) |=> !busy && !pendValid);
  p_commit_clears_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !pendValid);
endmodule

// File: rtl/pgbuf_datapath.sv
module pgbuf_datapath
  import pgbuf_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 18
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pgbufStrobes_t              strb,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [BUS_W-1:0]           busWData,
  input  logic [$clog2(SLOTS)-1:0]   slotIdx,
  input  logic                       errClear,
  output logic [2*BUS_W-1:0]         flData,
  output logic [ADDR_W-$clog2(BUS_W/8)-1-$clog2(SLOTS)-1:0] pageNum,
  output logic                       errFlag
);
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int DW_W     = 2 * BUS_W;
  localparam int LOW_BITS = $clog2(BUS_W / 8);
  localparam int DW_LSB   = LOW_BITS + 1;
  localparam int PAGE_W   = ADDR_W - DW_LSB - SLOT_W;

  logic [BUS_W-1:0]  lowWord;
  logic [SLOT_W-1:0] wrSlot;
  logic [PAGE_W-1:0] pageIn;
  logic [DW_W-1:0]   slotRd [SLOTS];

  assign wrSlot = busAddr[DW_LSB +: SLOT_W];
  assign pageIn = busAddr[ADDR_W-1 -: PAGE_W];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [DW_W-1:0] slotQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slotQ <= '1;
      else if (strb.fillErased)
        slotQ <= '1;
      else if (strb.commit && (wrSlot == SLOT_W'(g)))
        slotQ <= {busWData, lowWord};
    end
    assign slotRd[g] = slotQ;
  end

  assign flData = slotRd[slotIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowWord <= '0;
      pageNum <= '0;
      errFlag <= 1'b0;
    end else begin
      if (strb.stageLow) lowWord <= busWData;
      if (strb.loadPage) pageNum <= pageIn;
      errFlag <= strb.setErr || (errFlag && !errClear);
    end
  end

  p_erase_fill_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillErased |=> (slotRd[0] == '1) && (slotRd[SLOTS-1] == '1));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !errClear |=> errFlag);
  p_err_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.setErr |=> errFlag);
  p_commit_data_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> slotRd[$past(wrSlot)] == {$past(busWData), $past(lowWord)});
endmodule

// File: rtl/pgbuf_combiner.sv
module pgbuf_combiner
  import pgbuf_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 18,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int PAGE_W = ADDR_W - $clog2(BUS_W / 8) - 1 - SLOT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [1:0]          busSize,
  input  logic [BUS_W-1:0]    busWData,
  output logic                busReady,
  output logic [BUS_W-1:0]    busRData,
  input  logic                cmdWritePage,
  input  logic                errClear,
  output logic                errFlag,
  output logic [PAGE_W-1:0]   pageNum,
  output logic                busy,
  output logic                flValid,
  input  logic                flReady,
  output logic [SLOT_W-1:0]   flSlot,
  output logic [PAGE_W-1:0]   flPage,
  output logic [2*BUS_W-1:0]  flData
);
  pgbufStrobes_t strb;

  pgbuf_ctrl #(.SLOTS(SLOTS), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .cmdWritePage(cmdWritePage),
    .flReady(flReady), .busReady(busReady), .busy(busy), .flValid(flValid),
    .slotIdx(flSlot), .strb(strb)
  );

  pgbuf_datapath #(.SLOTS(SLOTS), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr), .busWData(busWData),
    .slotIdx(flSlot), .errClear(errClear), .flData(flData), .pageNum(pageNum),
    .errFlag(errFlag)
  );

  assign busRData = '0;
  assign flPage   = pageNum;

  p_page_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(pageNum));
  p_read_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busWrite |-> busRData == '0);
endmodule

// File: tb/pgbuf_combiner_bench.sv
module pgbuf_combiner_bench;
  localparam int SLOTS = 32, BUS_W = 32, ADDR_W = 18, PAGE_W = 10;

  logic clk = 0, rstN = 0;
  logic busValid = 0, busWrite = 0, cmdWritePage = 0, errClear = 0, flReady = 0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [1:0] busSize = 2'd2;
  logic [31:0] busWData = '0;
  logic busReady, errFlag, busy, flValid;
  logic [31:0] busRData;
  logic [PAGE_W-1:0] pageNum, flPage;
  logic [4:0] flSlot;
  logic [63:0] flData;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [63:0] expMem [SLOTS];
  logic [PAGE_W-1:0] expPage = '0;
  logic expErr = 0, pend = 0;
  logic [14:0] pendA = '0;
  logic [31:0] low = '0;

  pgbuf_combiner u_pgbuf_combiner (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busSize(busSize), .busWData(busWData), .busReady(busReady), .busRData(busRData),
    .cmdWritePage(cmdWritePage), .errClear(errClear), .errFlag(errFlag), .pageNum(pageNum),
    .busy(busy), .flValid(flValid), .flReady(flReady), .flSlot(flSlot), .flPage(flPage),
    .flData(flData)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] addrOf(input int page, input int slot, input int hi);
    return ADDR_W'(((page * SLOTS + slot) * 8) + hi * 4);
  endfunction

  task automatic busOp(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input bit wr,
                       input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    while (busy) @(negedge clk);
    busValid = 1; busWrite = wr; busAddr = a; busSize = sz; busWData = d;
    #1 rd = busRData;
    @(negedge clk);
    busValid = 0;
    if (!wr) expErr = 1;
    else if (sz != 2'd2 || a[1:0] != 2'b00) expErr = 1;
    else begin
      expPage = a[ADDR_W-1:8];
      if (!a[2]) begin pend = 1; pendA = a[ADDR_W-1:3]; low = d; end
      else if (pend && pendA == a[ADDR_W-1:3]) begin
        expMem[a[7:3]] = {d, low}; pend = 0;
      end else expErr = 1;
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    logic [31:0] rd;
    busOp(a, 2'd2, 1'b1, d, rd);
  endtask

  task automatic clearErr();
    @(negedge clk); errClear = 1;
    @(negedge clk); errClear = 0; expErr = 0;
  endtask

  task automatic copyOut(input string req, input bit injectCmd);
    logic [63:0] got [SLOTS];
    int beats = 0, cyc = 0;
    @(negedge clk); cmdWritePage = 1;
    @(negedge clk); cmdWritePage = 0;
    chk(busy === 1'b1 && busReady === 1'b0, "R9 busy after command", {busy, busReady}, 2'b10);
    while (beats < SLOTS) begin
      flReady = (cyc % 3) != 2;
      cmdWritePage = injectCmd && beats == 10;
      #1;
      if (flValid && flReady) begin
        chk(flSlot == 5'(beats), "R8 slot order", flSlot, beats);
        chk(flPage == expPage, "R8 page on beat", flPage, expPage);
        got[beats] = flData;
        beats++;
      end
      cyc++;
      @(negedge clk);
    end
    flReady = 0; cmdWritePage = 0;
    chk(busy === 1'b0, "R9 busy falls after last beat", busy, 0);
    @(negedge clk);
    chk(busy === 1'b0, "R9 no restart from command during busy", busy, 0);
    for (int i = 0; i < SLOTS; i++)
      chk(got[i] === expMem[i], {req, " slot data"}, got[i], expMem[i]);
    for (int i = 0; i < SLOTS; i++) expMem[i] = '1;
    pend = 0;
  endtask

  task automatic t_reset();
    chk(busy === 0 && busReady === 1 && flValid === 0, "R9 idle after reset", {busy, busReady, flValid}, 3'b010);
    chk(errFlag === 0, "R7 error clear after reset", errFlag, 0);
    chk(pageNum === 0, "R2 page after reset", pageNum, 0);
    copyOut("R10 R11 erased after reset", 1'b0);
  endtask

  task automatic t_pairs();
    wr(addrOf(3, 5, 0), 32'h1111_0005); wr(addrOf(3, 5, 1), 32'hAAAA_0005);
    wr(addrOf(3, 31, 0), 32'h2222_001F); wr(addrOf(3, 31, 1), 32'hBBBB_001F);
    wr(addrOf(7, 0, 0), 32'h3333_0000); wr(addrOf(7, 0, 1), 32'hCCCC_0000);
    chk(pageNum === 10'd7, "R2 page from last write", pageNum, 7);
    wr(addrOf(3, 1, 0), 32'h4444_0001); wr(addrOf(3, 1, 1), 32'hDDDD_0001);
    chk(pageNum === 10'd3, "R2 page reload", pageNum, 3);
    chk(errFlag === 0, "R1 no error on pairs", errFlag, 0);
    copyOut("R1 R11 paired data", 1'b1);
    copyOut("R10 erased after page write", 1'b0);
  endtask

  task automatic t_orphan();
    wr(addrOf(2, 4, 1), 32'hDEAD_0001);
    chk(errFlag === 1, "R3 lone upper word error", errFlag, 1);
    clearErr();
    wr(addrOf(2, 6, 0), 32'h5555_0006);
    wr(addrOf(2, 7, 1), 32'hDEAD_0007);
    chk(errFlag === 1, "R3 mismatched upper word error", errFlag, 1);
    wr(addrOf(2, 6, 1), 32'hEEEE_0006);
    copyOut("R3 orphan discarded, pending kept", 1'b0);
    clearErr();
  endtask

  task automatic t_replace();
    wr(addrOf(4, 9, 0), 32'h0000_0001);
    wr(addrOf(4, 9, 0), 32'h0000_0002);
    wr(addrOf(4, 9, 1), 32'h9999_0009);
    wr(addrOf(4, 10, 0), 32'h0000_0003);
    wr(addrOf(4, 11, 0), 32'h0000_0004);
    wr(addrOf(4, 10, 1), 32'h7777_000A);
    chk(errFlag === 1, "R4 replaced lower word no longer pairs", errFlag, 1);
    wr(addrOf(4, 11, 1), 32'h8888_000B);
    copyOut("R4 replacement", 1'b0);
    clearErr();
  endtask

  task automatic t_badSize();
    logic [31:0] rd;
    wr(addrOf(5, 2, 0), 32'h1234_5678);
    busOp(addrOf(9, 2, 1), 2'd0, 1'b1, 32'hFFFF_0000, rd);
    chk(errFlag === 1, "R5 byte write error", errFlag, 1);
    chk(pageNum === 10'd5, "R5 page unchanged by byte write", pageNum, 5);
    clearErr();
    busOp(addrOf(9, 2, 1), 2'd1, 1'b1, 32'hFFFF_0001, rd);
    chk(errFlag === 1, "R5 halfword write error", errFlag, 1);
    clearErr();
    busOp(addrOf(9, 2, 1) + 2, 2'd2, 1'b1, 32'hFFFF_0002, rd);
    chk(errFlag === 1, "R5 misaligned word error", errFlag, 1);
    chk(pageNum === 10'd5, "R5 page unchanged by misaligned", pageNum, 5);
    clearErr();
    wr(addrOf(5, 2, 1), 32'h9ABC_DEF0);
    chk(errFlag === 0, "R5 pending kept through bad writes", errFlag, 0);
    copyOut("R5 buffer untouched", 1'b0);
  endtask

  task automatic t_read();
    logic [31:0] rd;
    wr(addrOf(6, 3, 0), 32'h0F0F_0F0F);
    busOp(addrOf(8, 3, 1), 2'd2, 1'b0, 32'hFFFF_FFFF, rd);
    chk(rd === 32'h0, "R6 read returns zero", rd, 0);
    chk(errFlag === 1, "R6 read sets error", errFlag, 1);
    chk(pageNum === 10'd6, "R6 page unchanged by read", pageNum, 6);
    repeat (3) @(negedge clk);
    chk(errFlag === 1, "R7 error sticky", errFlag, 1);
    clearErr();
    chk(errFlag === 0, "R7 error cleared", errFlag, 0);
    wr(addrOf(6, 3, 1), 32'hF0F0_F0F0);
    copyOut("R6 read left buffer", 1'b0);
  endtask

  task automatic t_clearRace();
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = '0; busSize = 2'd2; errClear = 1;
    @(negedge clk);
    busValid = 0; errClear = 0;
    chk(errFlag === 1, "R7 new error beats clear", errFlag, 1);
    clearErr();
  endtask

  task automatic t_pendAcrossPage();
    wr(addrOf(1, 12, 0), 32'hCAFE_000C);
    copyOut("R10 pending lower word not written", 1'b0);
    wr(addrOf(1, 12, 1), 32'hBEEF_000C);
    chk(errFlag === 1, "R10 pending cleared by page write", errFlag, 1);
    copyOut("R10 buffer stays erased", 1'b0);
    clearErr();
  endtask

  initial begin
    for (int i = 0; i < SLOTS; i++) expMem[i] = '1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_pairs();
    t_orphan();
    t_replace();
    t_badSize();
    t_read();
    t_clearRace();
    t_pendAcrossPage();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule